// File: doc/BRIEF.md
# Configurable output logic macrocell

This block is one output cell of a sum-of-products programmable logic device. It takes eight product terms from the AND array and turns them into three results: a pin value, a tri-state enable for that pin, and a feedback signal back to the array. It also receives a shared clock, a shared active-low output-enable pin, the level seen on its own I/O pin, and static configuration bits.

Two global mode bits are shared by every cell of the device and pick one of three modes: simple, complex or registered. Each cell also has its own polarity bit and its own function bit. Together these bits decide how the terms are used. One term can serve as the output enable or be ORed into the sum. The enable can come from that term, from the shared pin, or be fixed. The feedback is taken either from the cell's flip-flop or from its pin. The flip-flop clears on power-on reset and can be loaded directly from a preload input for test.

Top module: `out_macrocell`

## Requirements
- R1: The mode bits `globalMode` = {sync bit, arch bit} decode as 2'b10 simple, 2'b11 complex and 2'b01 registered. The value 2'b00 is reserved: in it the pin enable is 0 and `fbOut` follows `pinIn`.
- R2: In simple mode with `cellFunc` = 0, `pinOe` is 1 and `pinOut` is the OR of all eight terms XOR `polInv`, in the same cycle.
- R3: In simple mode with `cellFunc` = 1, `pinOe` is 0 and `fbOut` follows `pinIn`, so the pin acts as a dedicated input.
- R4: In complex mode, `pinOe` equals `termIn[0]`, `pinOut` is the OR of `termIn[7:1]` XOR `polInv`, and `fbOut` follows `pinIn`. `cellFunc` has no effect on any output in this mode.
- R5: In registered mode with `cellFunc` = 1, the cell is combinational and behaves as in complex mode: term 0 is the enable and terms 7..1 are ORed.
- R6: In registered mode with `cellFunc` = 0, the flip-flop captures the OR of all eight terms XOR `polInv` on each rising `clk` edge. `pinOut` and `fbOut` both show the flip-flop, and `pinOe` is the inverse of `oePinN`.
- R7: Setting `polInv` = 1 inverts the data result in every mode, both combinational and registered.
- R8: While `rstN` is low, the flip-flop is 0 at once (asynchronous reset), so a registered cell then shows `pinOut` = 0 and `fbOut` = 0.
- R9: When `preloadEn` is 1 at a rising edge, the flip-flop loads `preloadVal` instead of the term sum.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Shared device clock |
| rstN | input | 1 | Power-on reset, active low, asynchronous |
| globalMode | input | 2 | Global mode bits {sync, arch} |
| cellFunc | input | 1 | Per-cell function bit |
| polInv | input | 1 | Per-cell output polarity (1 inverts) |
| termIn | input | 8 | Product terms from the AND array |
| oePinN | input | 1 | Shared output-enable pin, active low |
| pinIn | input | 1 | Level seen on the cell's I/O pin |
| preloadEn | input | 1 | Test preload strobe for the flip-flop |
| preloadVal | input | 1 | Value to preload |
| pinOut | output | 1 | Value driven toward the pin |
| pinOe | output | 1 | Tri-state enable for the pin |
| fbOut | output | 1 | Feedback to the AND array |

## Verification
Every combinational result settles in the same cycle as its inputs: the enable, the data in the simple, complex and combinational cases, and the feedback from the pin. The bench therefore changes inputs on the falling edge and samples one nanosecond later, before any rising edge can come between them. The registered data and the preload appear one rising edge after the inputs are applied, so those checks wait for that edge and sample 1 ns after it. Reset clears the flip-flop without a clock, so that check samples shortly after `rstN` falls, with no edge in between.

// File: rtl/mcell_pkg.sv
package mcell_pkg;

  typedef enum logic [1:0] {
    MODE_RSVD   = 2'b00,
    MODE_REG    = 2'b01,
    MODE_SIMPLE = 2'b10,
    MODE_CPLX   = 2'b11
  } mode_e;

  // Strobes from the mode decoder to the datapath
  typedef struct packed {
    logic useReg;      // data and feedback from flip-flop
    logic oeFromTerm;  // first product term enables the pin
    logic oeFromPin;   // shared active-low pin enables
    logic oeAlways;    // pin always driven
    logic dropFirst;   // first term excluded from the OR
  } strobe_t;

endpackage

// File: rtl/mcell_ctrl.sv
module mcell_ctrl
  import mcell_pkg::*;
(
  input  logic [1:0] globalMode,
  input  logic       cellFunc,
  output strobe_t    strb
);

  mode_e modeDec;

  always_comb begin
    modeDec = mode_e'(globalMode);
    strb = '0;
    unique case (modeDec)
      MODE_SIMPLE: begin
        strb.oeAlways = ~cellFunc;
      end
      MODE_CPLX: begin
        strb.oeFromTerm = 1'b1;
        strb.dropFirst  = 1'b1;
      end
      MODE_REG: begin
        if (cellFunc) begin
          strb.oeFromTerm = 1'b1;
          strb.dropFirst  = 1'b1;
        end else begin
          strb.useReg    = 1'b1;
          strb.oeFromPin = 1'b1;
        end
      end
      default: strb = '0;
    endcase
  end

  // Only one enable source may be selected at a time
  always_comb begin
    assert_one_oe_src_R1: assert ($onehot0({strb.oeFromTerm, strb.oeFromPin, strb.oeAlways}));
  end

endmodule

// File: rtl/mcell_dpath.sv
module mcell_dpath
  import mcell_pkg::*;
#(
  parameter int NTERM = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  strobe_t          strb,
  input  logic             polInv,
  input  logic [NTERM-1:0] termIn,
  input  logic             oePinN,
  input  logic             pinIn,
  input  logic             preloadEn,
  input  logic             preloadVal,
  output logic             pinOut,
  output logic             pinOe,
  output logic             fbOut
);

  localparam int LAST = NTERM - 1;

  logic [NTERM-1:0] orChain;   // OR of terms 1..i
  logic sumAll, sumRest, combVal, regD, regQ;

  assign orChain[0] = 1'b0;
  generate
    for (genvar i = 1; i < NTERM; i++) begin : g_or
      assign orChain[i] = orChain[i-1] | termIn[i];
    end
  endgenerate

  assign sumRest = orChain[LAST];
  assign sumAll  = sumRest | termIn[0];
  assign combVal = (strb.dropFirst ? sumRest : sumAll) ^ polInv;
  assign regD    = sumAll ^ polInv;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          regQ <= 1'b0;
    else if (preloadEn) regQ <= preloadVal;
    else                regQ <= regD;
  end

  assign pinOut = strb.useReg ? regQ : combVal;
  assign fbOut  = strb.useReg ? regQ : pinIn;
  assign pinOe  = strb.oeAlways
                | (strb.oeFromTerm & termIn[0])
                | (strb.oeFromPin & ~oePinN);

  // R9: preload wins over the captured sum
  assert_preload_load_R9: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(preloadEn)) |-> (regQ == $past(preloadVal)));

  // R6: registered cell shows the sum captured at the previous edge
  assert_reg_capture_R6: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && !$past(preloadEn) && strb.useReg)
      |-> (pinOut == ($past(|termIn) ^ $past(polInv))));

endmodule

// File: rtl/out_macrocell.sv
module out_macrocell
  import mcell_pkg::*;
#(
  parameter int NTERM = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [1:0]       globalMode,
  input  logic             cellFunc,
  input  logic             polInv,
  input  logic [NTERM-1:0] termIn,
  input  logic             oePinN,
  input  logic             pinIn,
  input  logic             preloadEn,
  input  logic             preloadVal,
  output logic             pinOut,
  output logic             pinOe,
  output logic             fbOut
);

  strobe_t strb;

  mcell_ctrl i_ctrl (
    .globalMode(globalMode),
    .cellFunc  (cellFunc),
    .strb      (strb)
  );

  mcell_dpath #(.NTERM(NTERM)) i_dpath (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .polInv    (polInv),
    .termIn    (termIn),
    .oePinN    (oePinN),
    .pinIn     (pinIn),
    .preloadEn (preloadEn),
    .preloadVal(preloadVal),
    .pinOut    (pinOut),
    .pinOe     (pinOe),
    .fbOut     (fbOut)
  );

  assert_rsvd_off_R1: assert property (@(posedge clk) disable iff (!rstN)
    (globalMode == 2'b00) |-> (!pinOe && fbOut == pinIn));

  assert_simple_on_R2: assert property (@(posedge clk) disable iff (!rstN)
    (globalMode == 2'b10 && !cellFunc) |-> pinOe);

  assert_simple_in_R3: assert property (@(posedge clk) disable iff (!rstN)
    (globalMode == 2'b10 && cellFunc) |-> (!pinOe && fbOut == pinIn));

  assert_cplx_oe_R4: assert property (@(posedge clk) disable iff (!rstN)
    (globalMode == 2'b11) |-> (pinOe == termIn[0]));

  assert_reg_oe_R6: assert property (@(posedge clk) disable iff (!rstN)
    (globalMode == 2'b01 && !cellFunc) |-> (pinOe == !oePinN && fbOut == pinOut));

endmodule

// File: tb/test_out_macrocell.sv
`timescale 1ns/1ps
module test_out_macrocell;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [1:0] globalMode = 2'b10;
  logic cellFunc = 1'b0, polInv = 1'b0, oePinN = 1'b1, pinIn = 1'b0;
  logic preloadEn = 1'b0, preloadVal = 1'b0;
  logic [7:0] termIn = '0;
  logic pinOut, pinOe, fbOut;
  int total = 0, bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  out_macrocell i_out_macrocell (
    .clk(clk), .rstN(rstN), .globalMode(globalMode), .cellFunc(cellFunc),
    .polInv(polInv), .termIn(termIn), .oePinN(oePinN), .pinIn(pinIn),
    .preloadEn(preloadEn), .preloadVal(preloadVal),
    .pinOut(pinOut), .pinOe(pinOe), .fbOut(fbOut)
  );

  task automatic chk(string req, string what, logic act, logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%b expected=%b", req, what, act, exp);
    end
  endtask

  task automatic setComb(logic [1:0] m, logic f, logic p, logic [7:0] t);
    @(negedge clk);
    globalMode = m; cellFunc = f; polInv = p; termIn = t;
    #1;
  endtask

  task automatic test_reset_R8();
    globalMode = 2'b01; cellFunc = 0; termIn = 8'hFF;
    #1;
    chk("R8", "pinOut in reset", pinOut, 1'b0);
    chk("R8", "fbOut in reset", fbOut, 1'b0);
  endtask

  task automatic test_simple_R2();
    logic [7:0] pats [4] = '{8'h00, 8'h01, 8'h80, 8'h24};
    foreach (pats[i]) for (int p = 0; p < 2; p++) begin
      setComb(2'b10, 0, p[0], pats[i]);
      chk("R2", "simple oe", pinOe, 1'b1);
      chk(p ? "R7" : "R2", "simple data", pinOut, (|pats[i]) ^ p[0]);
    end
  endtask

  task automatic test_simple_in_R3();
    for (int v = 0; v < 2; v++) begin
      setComb(2'b10, 1, 0, 8'hFF);
      pinIn = v[0]; #1;
      chk("R3", "dedicated input oe", pinOe, 1'b0);
      chk("R3", "dedicated input fb", fbOut, v[0]);
    end
  endtask

  task automatic test_complex_R4();
    logic [7:0] pats [4] = '{8'h01, 8'h00, 8'h03, 8'h40};
    foreach (pats[i]) for (int f = 0; f < 2; f++) begin
      setComb(2'b11, f[0], 0, pats[i]);
      pinIn = pats[i][6]; #1;
      chk("R4", "complex oe", pinOe, pats[i][0]);
      chk("R4", "complex data", pinOut, |pats[i][7:1]);
      chk("R4", "complex fb", fbOut, pats[i][6]);
    end
    setComb(2'b11, 1, 1, 8'h01);
    chk("R7", "complex inverted", pinOut, 1'b1);
  endtask

  task automatic test_regcomb_R5();
    setComb(2'b01, 1, 0, 8'h01);
    chk("R5", "reg-comb oe", pinOe, 1'b1);
    chk("R5", "reg-comb data excludes term0", pinOut, 1'b0);
    setComb(2'b01, 1, 1, 8'h10);
    chk("R5", "reg-comb oe off", pinOe, 1'b0);
    chk("R5", "reg-comb inverted data", pinOut, 1'b0);
  endtask

  task automatic regStep(logic p, logic [7:0] t, logic oeN, string req);
    @(negedge clk);
    globalMode = 2'b01; cellFunc = 0; polInv = p; termIn = t; oePinN = oeN;
    @(posedge clk); #1;
    chk(req, "registered data", pinOut, (|t) ^ p);
    chk(req, "registered fb", fbOut, (|t) ^ p);
    chk("R6", "registered oe", pinOe, ~oeN);
  endtask

  task automatic test_registered_R6();
    regStep(0, 8'h01, 0, "R6");
    regStep(0, 8'h00, 1, "R6");
    regStep(1, 8'h00, 0, "R7");
    regStep(1, 8'h20, 1, "R7");
  endtask

  task automatic test_preload_R9();
    for (int v = 0; v < 2; v++) begin
      @(negedge clk);
      globalMode = 2'b01; cellFunc = 0; polInv = 0;
      termIn = v ? 8'h00 : 8'hFF; preloadEn = 1; preloadVal = v[0];
      @(posedge clk); #1;
      chk("R9", "preload value", pinOut, v[0]);
    end
    @(negedge clk); preloadEn = 0;
  endtask

  task automatic test_reserved_R1();
    for (int v = 0; v < 2; v++) begin
      setComb(2'b00, v[0], 0, 8'hFF);
      oePinN = 0; pinIn = v[0]; #1;
      chk("R1", "reserved oe", pinOe, 1'b0);
      chk("R1", "reserved fb", fbOut, v[0]);
    end
  endtask

  task automatic test_async_reset_R8();
    @(negedge clk);
    globalMode = 2'b01; cellFunc = 0; preloadEn = 1; preloadVal = 1;
    @(posedge clk); #1;
    chk("R8", "preloaded before reset", pinOut, 1'b1);
    preloadEn = 0; termIn = 8'hFF;
    rstN = 0; #0.5;
    chk("R8", "async clear", pinOut, 1'b0);
    @(negedge clk); rstN = 1;
  endtask

  initial begin
    test_reset_R8();
    repeat (2) @(negedge clk);
    rstN = 1;
    test_simple_R2();
    test_simple_in_R3();
    test_complex_R4();
    test_regcomb_R5();
    test_registered_R6();
    test_preload_R9();
    test_reserved_R1();
    test_async_reset_R8();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule